// File: doc/BRIEF.md
# Infrared Carrier Burst Timer

This block produces the modulated drive for an infrared remote-control transmitter. Software loads a timer word that holds a 9-bit burst length and a carrier-enable bit. While the count runs, a carrier taken from a free-running divider of the oscillator clock is gated onto the infrared output, and an idle indicator drops low. When the count is used up, a one-cycle done pulse is raised so that a halted processor can resume.

The count steps on the machine-cycle enable, which comes once every eight oscillator cycles. A burst of length value V therefore lasts (V + 1) machine cycles. The carrier runs at the oscillator clock divided by 8 or by 12. At divide-by-12 the duty is either one half or one third. A new word written at the edge where the count would end extends the burst with no break in the output.

Top module: `ir_burst_timer`

## Requirements
- R1: While rst_ni is low, and after it is released, the counter and the carrier-enable bit are zero, rem_o is 0, idle_o is 1 and done_o is 0. An assertion of rst_ni during a burst forces these values at once.
- R2: A write (wr_en_i = 1) loads wr_data_i[8:0] as the burst length V and wr_data_i[9] as the carrier-enable bit. The burst stays active for exactly V + 1 edges at which mcyc_en_i and run_i are both 1. A write takes priority over a count step at the same edge.
- R3: While run_i is 0, the count holds its value and the burst is inactive. When run_i returns to 1, counting resumes from the held value.
- R4: done_o is 1 for exactly one cycle, namely the cycle after the edge where a count step brings the count to zero. It is 0 at every other time.
- R5: When div_sel_i = 0, the carrier period is 8 clock cycles: high for phases 0..3 and low for phases 4..7.
- R6: When div_sel_i = 1, the carrier period is 12 clock cycles. It is high for phases 0..5 when duty_third_i = 0, and for phases 0..3 when duty_third_i = 1.
- R7: rem_o equals the carrier only while run_i is 1, the carrier-enable bit is 1 and the count is nonzero. At all other times rem_o is 0, including during a burst loaded with the carrier-enable bit at 0.
- R8: idle_o is 0 exactly while the condition of R7 holds, and 1 otherwise.
- R9: A write at the same edge as the final count step starts the new count with no done pulse. rem_o and idle_o then continue with no gap.
- R10: The carrier phase counts up from 0 after reset on every clock, whether or not a burst is active, and is never restarted by a load. When the phase is at or beyond the last phase of the selected divider, the next phase is 0, even if div_sel_i changed just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcyc_en_i | input | 1 | Machine-cycle enable, one cycle in eight |
| run_i | input | 1 | 1 = count, 0 = hold and gate off |
| wr_en_i | input | 1 | Timer word write strobe |
| wr_data_i | input | 10 | Bit 9 carrier enable, bits 8..0 burst length |
| div_sel_i | input | 1 | Carrier divider: 0 = /8, 1 = /12 |
| duty_third_i | input | 1 | Duty at /12: 0 = 1/2, 1 = 1/3 |
| rem_o | output | 1 | Modulated infrared drive |
| idle_o | output | 1 | Low while a carrier burst is being driven |
| done_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
All three outputs are decoded without further registers from state that updates on the rising edge. A write, a count step or a phase advance is therefore visible in the half cycle after the edge that takes it. done_o is high for the one cycle after the edge where the count becomes zero. The bench changes inputs 1 ns after each rising edge and compares rem_o, idle_o and done_o at the following falling edge. Each expected sample is queued at the moment of driving, so every comparison is tied to the edge that produced it. Asynchronous reset is checked a few nanoseconds after it is asserted, before any edge.

// File: rtl/ir_burst_pkg.sv
package ir_burst_pkg;
  typedef enum logic {
    CAR_DIV_LO = 1'b0,
    CAR_DIV_HI = 1'b1
  } car_div_e;

  typedef enum logic {
    DUTY_HALF  = 1'b0,
    DUTY_THIRD = 1'b1
  } car_duty_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/carrier_gen.sv
module carrier_gen
  import ir_burst_pkg::*;
#(
  parameter int unsigned DIV_LO = 8,
  parameter int unsigned DIV_HI = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_sel_i,
  input  logic duty_third_i,
  output logic car_o
);
  localparam int unsigned PH_MAX = max_u(DIV_LO, DIV_HI) - 1;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);

  logic [PH_W-1:0] ph_q, ph_last, hi_len;
  car_div_e  div_sel;
  car_duty_e duty_sel;

  assign div_sel  = car_div_e'(div_sel_i);
  assign duty_sel = car_duty_e'(duty_third_i);

  always_comb begin
    if (div_sel == CAR_DIV_HI) begin
      ph_last = PH_W'(DIV_HI - 1);
      hi_len  = (duty_sel == DUTY_THIRD) ? PH_W'(DIV_HI / 3) : PH_W'(DIV_HI / 2);
    end else begin
      ph_last = PH_W'(DIV_LO - 1);
      hi_len  = PH_W'(DIV_LO / 2);
    end
  end

  // free-running: a load never restarts the phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (ph_q >= ph_last)  ph_q <= '0;
    else                       ph_q <= ph_q + PH_W'(1);
  end

  assign car_o = (ph_q < hi_len);

  assert_phase_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ph_q) <= PH_MAX);
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mcyc_en_i,
  input  logic           run_i,
  input  logic           wr_en_i,
  input  logic [CNT_W:0] wr_data_i,
  output logic           cnt_nz_o,
  output logic           car_en_o,
  output logic           done_o
);
  // one extra bit: the register holds V+1 so the window is (V+1) ticks
  localparam int unsigned Q_W = CNT_W + 1;

  logic [Q_W-1:0] cnt_q;
  logic           lat_q, done_q, step;

  assign step = run_i & mcyc_en_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lat_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_en_i) begin
      cnt_q  <= Q_W'(wr_data_i[CNT_W-1:0]) + Q_W'(1);
      lat_q  <= wr_data_i[CNT_W];
      done_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_q - Q_W'(1);
      done_q <= (cnt_q == Q_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign cnt_nz_o = (cnt_q != '0);
  assign car_en_o = lat_q;
  assign done_o   = done_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cnt_q == Q_W'($past(wr_data_i[CNT_W-1:0])) + Q_W'(1)) && (lat_q == $past(wr_data_i[CNT_W])));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(cnt_q));
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == '0));
endmodule

// File: rtl/rem_gate.sv
module rem_gate (
  input  logic car_i,
  input  logic run_i,
  input  logic car_en_i,
  input  logic cnt_nz_i,
  output logic rem_o,
  output logic idle_o
);
  logic active;

  assign active = run_i & car_en_i & cnt_nz_i;
  assign rem_o  = active & car_i;
  assign idle_o = ~active;
endmodule

// File: rtl/ir_burst_timer.sv
module ir_burst_timer #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned DIV_LO = 8,
  parameter int unsigned DIV_HI = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mcyc_en_i,
  input  logic           run_i,
  input  logic           wr_en_i,
  input  logic [CNT_W:0] wr_data_i,
  input  logic           div_sel_i,
  input  logic           duty_third_i,
  output logic           rem_o,
  output logic           idle_o,
  output logic           done_o
);
  logic car, car_en, cnt_nz;

  carrier_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_car (
    .clk_i, .rst_ni, .div_sel_i, .duty_third_i, .car_o(car)
  );

  burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mcyc_en_i, .run_i, .wr_en_i, .wr_data_i,
    .cnt_nz_o(cnt_nz), .car_en_o(car_en), .done_o
  );

  rem_gate u_gate (
    .car_i(car), .run_i, .car_en_i(car_en), .cnt_nz_i(cnt_nz), .rem_o, .idle_o
  );

  assert_rem_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_o |-> !idle_o);
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_o);
  assert_nolatch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !car_en |-> (!rem_o && idle_o));
endmodule

// File: tb/ir_burst_timer_tb_top.sv
`timescale 1ns/1ps
module ir_burst_timer_tb_top;
  localparam int CNT_W = 9, DIV_LO = 8, DIV_HI = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, mcyc_en, run, wr_en, div_sel, duty_third;
  logic [CNT_W:0] wr_data;
  logic rem, idle, done;

  ir_burst_timer #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mcyc_en_i(mcyc_en), .run_i(run), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .div_sel_i(div_sel), .duty_third_i(duty_third),
    .rem_o(rem), .idle_o(idle), .done_o(done)
  );

  typedef struct { logic rem; logic idle; logic done; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;

  int m_cnt, m_lat, m_done, m_ph, bc;
  logic p_wr, p_run, p_mc, p_div;
  logic [CNT_W:0] p_data;
  logic g_run, g_div, g_duty, g_arm;
  logic [CNT_W:0] g_arm_data;
  string g_tag;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: one queued item per falling edge
  initial forever begin
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, "rem", rem, e.rem);
      check("R8", "idle", idle, e.idle);
      check({e.tag, "/R4"}, "done", done, e.done);
    end
  end

  task automatic model_reset();
    m_cnt = 0; m_lat = 0; m_done = 0; m_ph = 0;
    p_wr = 1'b0; p_data = '0;
  endtask

  // driver: one clock, queues the expected output for this cycle
  task automatic cyc(input logic wr, input logic [CNT_W:0] data);
    int nlast, hi;
    logic mc, act, w;
    logic [CNT_W:0] d;
    @(posedge clk);
    if (p_wr) begin
      m_cnt = int'(p_data[CNT_W-1:0]) + 1; m_lat = int'(p_data[CNT_W]); m_done = 0;
    end else if (p_run && p_mc && m_cnt != 0) begin
      m_done = (m_cnt == 1) ? 1 : 0; m_cnt--;
    end else m_done = 0;
    nlast = p_div ? DIV_HI - 1 : DIV_LO - 1;
    m_ph  = (m_ph >= nlast) ? 0 : m_ph + 1;
    #1;
    bc = (bc + 1) % 8;
    mc = (bc == 7);
    w = wr; d = data;
    if (g_arm && m_cnt == 1 && mc) begin w = 1'b1; d = g_arm_data; g_arm = 1'b0; end
    wr_en = w; wr_data = d; mcyc_en = mc; run = g_run; div_sel = g_div; duty_third = g_duty;
    p_wr = w; p_data = d; p_mc = mc; p_run = g_run; p_div = g_div;
    hi  = g_div ? (g_duty ? DIV_HI / 3 : DIV_HI / 2) : DIV_LO / 2;
    act = g_run && (m_lat != 0) && (m_cnt != 0);
    q.push_back('{act && (m_ph < hi), !act, (m_done != 0), g_tag});
  endtask

  task automatic run_n(input int n);
    repeat (n) cyc(1'b0, '0);
  endtask

  task automatic load(input int v, input logic lat);
    cyc(1'b1, {lat, CNT_W'(v)});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; mcyc_en = 0; run = 0; wr_en = 0; wr_data = '0; div_sel = 0; duty_third = 0;
    g_run = 1'b1; g_div = 1'b0; g_duty = 1'b0; g_arm = 1'b0; g_arm_data = '0; g_tag = "R1";
    bc = 0; p_run = 0; p_mc = 0; p_div = 0;
    model_reset();
    #3;
    check("R1", "rem in reset", rem, 1'b0);
    check("R1", "idle in reset", idle, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    check("R1", "rem after reset", rem, 1'b0);
    check("R1", "idle after reset", idle, 1'b1);
    check("R1", "done after reset", done, 1'b0);

    g_tag = "R5"; load(3, 1'b1); run_n(40);
    g_tag = "R7"; load(2, 1'b0); run_n(30);
    g_tag = "R6"; g_div = 1'b1; g_duty = 1'b0; load(4, 1'b1); run_n(50);
    g_duty = 1'b1; load(4, 1'b1); run_n(50);
    g_tag = "R3"; g_div = 1'b0; load(5, 1'b1); run_n(12);
    g_run = 1'b0; run_n(20); g_run = 1'b1; run_n(50);
    g_tag = "R4"; load(0, 1'b1); run_n(20);
    g_tag = "R2"; load(9'h1FF, 1'b1); run_n(4200);
    load(6, 1'b1); run_n(5); load(1, 1'b1); run_n(30);
    g_tag = "R9"; g_arm_data = {1'b1, CNT_W'(3)}; load(2, 1'b1); g_arm = 1'b1; run_n(60);
    g_tag = "R10"; g_div = 1'b1; load(20, 1'b1);
    for (int i = 0; i < 20 && m_ph != 9; i++) cyc(1'b0, '0);
    g_div = 1'b0; run_n(30);

    g_tag = "R1"; load(10, 1'b1); run_n(20);
    @(posedge clk); #1 rst_ni = 1'b0;
    #3;
    check("R1", "rem on async reset", rem, 1'b0);
    check("R1", "idle on async reset", idle, 1'b1);
    check("R1", "done on async reset", done, 1'b0);
    model_reset();
    wr_en = 1'b0; p_wr = 1'b0;
    @(posedge clk); #1 rst_ni = 1'b1;
    run_n(30);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule